// File: doc/BRIEF.md
# Sequence Register Bank with Command Sequencer

This block holds eight operand sequences for a frequency-domain field arithmetic unit. Each sequence is 26 words of 13 bits. A small command sequencer moves those sequences word by word between the storage, the host data pins, an internal modular adder and an external multiplier. Each register is a recirculating shift FIFO, not an addressed RAM. A word that leaves a register it reads is fed back into that register's tail, unless the same register is the destination. After any full command every register is therefore rotated back to its original alignment.

A host places a command on the command pins and pulses `start` while the block is idle. The block then takes one decode cycle and runs the data phase. At the end it pulses `done` for a single cycle. Loads take words from `din`. Reads present words on `dout` together with a valid flag. Add and subtract use arithmetic modulo 2^13-1. Multiplication and the two domain conversions stream their operands to an external multiplier, wait for its completion pulse, and then collect 26 result words into the destination register.

Top module: `seq_cmd_unit`

## Requirements
- R1: After reset every register word is 0 and `busy`, `done`, `dout_valid`, `mul_strm` and `mul_pop` are low.
- R2: A command is captured on a clock edge where `start` is high and `busy` is low. `busy` is high from the next cycle through the cycle in which `done` is high. A `start` pulse while `busy` is high is ignored and has no effect on any register.
- R3: Commands that do not use the multiplier take one decode cycle, then 26 data cycles (loads may stall), then one cycle with `done` high, after which the block is idle.
- R4: Opcode 0 (load) writes register `cmd_ra`. In each data cycle with `load` high, `din` is taken as the next word, index 0 first. A data cycle with `load` low takes nothing and does not advance.
- R5: Opcode 1 (read) raises `dout_valid` for exactly 26 cycles and presents word k of `cmd_ra` in the k-th of them. Reading does not change the register, so repeated reads return the same words.
- R6: Opcode 3 (add) writes word k of `cmd_rc` as s = a_k + b_k, where a comes from `cmd_ra` and b from `cmd_rb`. If s >= 8192 the result is s - 8192 + 1, otherwise s. Source registers that are not the destination are unchanged.
- R7: Opcode 4 (subtract) writes `cmd_rc` with the same end-around rule applied to a_k + (8191 - b_k), which is a_k plus the bitwise complement of b_k.
- R8: Opcode 5 (move) copies register `cmd_ra` into register `cmd_rb` and leaves `cmd_ra` unchanged.
- R9: When the destination is also a source, each old word is consumed as the new word is written, so in-place operations give the same result as with a separate destination.
- R10: Opcodes 2 (multiply `cmd_ra` by `cmd_rb` into `cmd_rc`), 6 (forward transform of `cmd_ra`) and 7 (inverse transform of `cmd_ra`) run as follows. After decode, `mul_strm` is high for 26 cycles carrying word k of `cmd_ra` on `mul_a`. `mul_b` carries word k of `cmd_rb` for opcode 2 and 0 otherwise. `mul_op` is 0, 1 or 2 respectively. The block then waits for a `mul_done` pulse. In the cycle after that pulse, `mul_pop` goes high for 26 cycles, and word k of the result is taken from `mul_c` in the k-th of them. The destination is `cmd_rc` for opcode 2 and `cmd_ra` for opcodes 6 and 7. `done` follows one cycle later.
- R11: Registers not named as destination by a command keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 3 | Opcode |
| cmd_ra | input | 3 | First register field |
| cmd_rb | input | 3 | Second register field |
| cmd_rc | input | 3 | Third register field |
| load | input | 1 | Load word valid |
| din | input | 13 | Load word |
| dout | output | 13 | Read word (0 when not valid) |
| dout_valid | output | 1 | Read word valid |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| mul_op | output | 2 | Multiplier operation code |
| mul_strm | output | 1 | Operand words valid on mul_a/mul_b |
| mul_a | output | 13 | First operand word |
| mul_b | output | 13 | Second operand word |
| mul_done | input | 1 | Multiplier finished pulse |
| mul_pop | output | 1 | Result word taken from mul_c this cycle |
| mul_c | input | 13 | Multiplier result word |

## Verification
A wrong shift enable or tail select in the storage shows up as a word misplaced in a register. That error appears on `dout` or `mul_a` in the very next read or stream cycle that reaches the damaged index. A register that misses a recirculation shows up as a rotation on its next read. A sequencer that miscounts shows up within a cycle as a `done`, `dout_valid`, `mul_strm` or `mul_pop` edge one cycle off. This is why the outputs are compared against a behavioural model in every cycle, and why reads are repeated after every write.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int SEQ_W     = 13;
    localparam int SEQ_DEPTH = 26;
    localparam int SEQ_NREG  = 8;

    typedef enum logic [2:0] {
        OP_LOAD = 3'd0,
        OP_READ = 3'd1,
        OP_MUL  = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4,
        OP_MOVE = 3'd5,
        OP_FWD  = 3'd6,
        OP_INV  = 3'd7
    } seq_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEC,
        ST_DATA,
        ST_MSTR,
        ST_MWAIT,
        ST_MRES,
        ST_FIN
    } seq_st_e;

    typedef enum logic [1:0] {
        TS_DIN,
        TS_ALU,
        TS_HEADA,
        TS_MULC
    } tail_src_e;

    typedef enum logic [1:0] {
        MK_MULT = 2'd0,
        MK_FWD  = 2'd1,
        MK_INV  = 2'd2
    } mul_kind_e;

    typedef struct packed {
        logic busy;
        logic done;
        logic rd_valid;
        logic strm;
        logic pop;
    } seq_flags_t;

    function automatic logic uses_mul(seq_op_e op);
        return (op == OP_MUL) || (op == OP_FWD) || (op == OP_INV);
    endfunction

    function automatic mul_kind_e kind_of(seq_op_e op);
        case (op)
            OP_FWD:  return MK_FWD;
            OP_INV:  return MK_INV;
            default: return MK_MULT;
        endcase
    endfunction

    function automatic tail_src_e tail_of(seq_op_e op);
        case (op)
            OP_LOAD:        return TS_DIN;
            OP_ADD, OP_SUB: return TS_ALU;
            OP_MOVE:        return TS_HEADA;
            default:        return TS_MULC;
        endcase
    endfunction

endpackage

// File: rtl/seq_fifo.sv
module seq_fifo #(
    parameter int W     = 13,
    parameter int DEPTH = 26
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic [W-1:0] tail,
    output logic [W-1:0] head
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (shift) begin
            for (int i = 0; i < DEPTH - 1; i++) mem[i] <= mem[i+1];
            mem[DEPTH-1] <= tail;
        end
    end

    assign head = mem[0];

endmodule

// File: rtl/seq_fadd.sv
module seq_fadd #(
    parameter int W = 13
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);

    logic [W-1:0] b_eff;
    logic [W:0]   raw;

    always_comb begin
        // complement is negation modulo 2^W-1; carry out wraps to bit 0
        b_eff = sub ? ~b : b;
        raw   = {1'b0, a} + {1'b0, b_eff};
        y     = raw[W-1:0] + W'(raw[W]);
    end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
#(
    parameter  int NREG  = 8,
    parameter  int DEPTH = 26,
    localparam int RAW   = $clog2(NREG),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  seq_op_e         op_i,
    input  logic [RAW-1:0]  ra_i,
    input  logic [RAW-1:0]  rb_i,
    input  logic [RAW-1:0]  rc_i,
    input  logic            load,
    input  logic            mul_done,
    output logic [RAW-1:0]  sel_a,
    output logic [RAW-1:0]  sel_b,
    output logic [NREG-1:0] shift_v,
    output logic [NREG-1:0] wr_v,
    output tail_src_e       tail_src,
    output logic            alu_sub,
    output seq_flags_t      flags,
    output mul_kind_e       mkind,
    output logic            b_live
);

    seq_st_e        st;
    seq_op_e        op_q;
    logic [RAW-1:0] ra_q, rb_q, rc_q;
    logic [CW-1:0]  cnt;
    logic           step;
    logic           last;

    assign last = (cnt == CW'(DEPTH - 1));
    assign step = ((st == ST_DATA) && ((op_q != OP_LOAD) || load)) ||
                  (st == ST_MSTR) || (st == ST_MRES);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            op_q <= OP_LOAD;
            ra_q <= '0;
            rb_q <= '0;
            rc_q <= '0;
            cnt  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    op_q <= op_i;
                    ra_q <= ra_i;
                    rb_q <= rb_i;
                    rc_q <= rc_i;
                    st   <= ST_DEC;
                end
                ST_DEC: begin
                    cnt <= '0;
                    st  <= uses_mul(op_q) ? ST_MSTR : ST_DATA;
                end
                ST_DATA, ST_MSTR, ST_MRES: if (step) begin
                    if (last) begin
                        cnt <= '0;
                        st  <= (st == ST_MSTR) ? ST_MWAIT : ST_FIN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_MWAIT: if (mul_done) st <= ST_MRES;
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    logic           use_a, use_b, use_d;
    logic [RAW-1:0] dst;
    logic [NREG-1:0] rd_v;

    always_comb begin
        use_a = 1'b0;
        use_b = 1'b0;
        use_d = 1'b0;
        dst   = ra_q;
        case (st)
            ST_DATA: begin
                case (op_q)
                    OP_LOAD: use_d = 1'b1;
                    OP_READ: use_a = 1'b1;
                    OP_ADD, OP_SUB: begin
                        use_a = 1'b1;
                        use_b = 1'b1;
                        use_d = 1'b1;
                        dst   = rc_q;
                    end
                    OP_MOVE: begin
                        use_a = 1'b1;
                        use_d = 1'b1;
                        dst   = rb_q;
                    end
                    default: ;
                endcase
            end
            ST_MSTR: begin
                use_a = 1'b1;
                use_b = (op_q == OP_MUL);
            end
            ST_MRES: begin
                use_d = 1'b1;
                dst   = (op_q == OP_MUL) ? rc_q : ra_q;
            end
            default: ;
        endcase

        rd_v = '0;
        wr_v = '0;
        if (step) begin
            if (use_a) rd_v[ra_q] = 1'b1;
            if (use_b) rd_v[rb_q] = 1'b1;
            if (use_d) wr_v[dst]  = 1'b1;
        end
        shift_v = rd_v | wr_v;
    end

    assign sel_a    = ra_q;
    assign sel_b    = rb_q;
    assign tail_src = tail_of(op_q);
    assign alu_sub  = (op_q == OP_SUB);
    assign mkind    = kind_of(op_q);
    assign b_live   = (op_q == OP_MUL);

    assign flags.busy     = (st != ST_IDLE);
    assign flags.done     = (st == ST_FIN);
    assign flags.rd_valid = (st == ST_DATA) && (op_q == OP_READ);
    assign flags.strm     = (st == ST_MSTR);
    assign flags.pop      = (st == ST_MRES);

endmodule

// File: rtl/seq_cmd_unit.sv
module seq_cmd_unit
    import seq_pkg::*;
#(
    parameter  int W     = SEQ_W,
    parameter  int DEPTH = SEQ_DEPTH,
    parameter  int NREG  = SEQ_NREG,
    localparam int RAW   = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [2:0]     cmd_op,
    input  logic [RAW-1:0] cmd_ra,
    input  logic [RAW-1:0] cmd_rb,
    input  logic [RAW-1:0] cmd_rc,
    input  logic           load,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   dout,
    output logic           dout_valid,
    output logic           busy,
    output logic           done,
    output logic [1:0]     mul_op,
    output logic           mul_strm,
    output logic [W-1:0]   mul_a,
    output logic [W-1:0]   mul_b,
    input  logic           mul_done,
    output logic           mul_pop,
    input  logic [W-1:0]   mul_c
);

    logic [RAW-1:0]  sel_a, sel_b;
    logic [NREG-1:0] shift_v, wr_v;
    tail_src_e       tail_src;
    logic            alu_sub;
    seq_flags_t      flags;
    mul_kind_e       mkind;
    logic            b_live;

    seq_ctrl #(.NREG(NREG), .DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .op_i     (seq_op_e'(cmd_op)),
        .ra_i     (cmd_ra),
        .rb_i     (cmd_rb),
        .rc_i     (cmd_rc),
        .load     (load),
        .mul_done (mul_done),
        .sel_a    (sel_a),
        .sel_b    (sel_b),
        .shift_v  (shift_v),
        .wr_v     (wr_v),
        .tail_src (tail_src),
        .alu_sub  (alu_sub),
        .flags    (flags),
        .mkind    (mkind),
        .b_live   (b_live)
    );

    logic [W-1:0] head [NREG];
    logic [W-1:0] head_a, head_b, alu_y, new_word;

    assign head_a = head[sel_a];
    assign head_b = head[sel_b];

    seq_fadd #(.W(W)) u_fadd (
        .a   (head_a),
        .b   (head_b),
        .sub (alu_sub),
        .y   (alu_y)
    );

    always_comb begin
        case (tail_src)
            TS_DIN:   new_word = din;
            TS_ALU:   new_word = alu_y;
            TS_HEADA: new_word = head_a;
            default:  new_word = mul_c;
        endcase
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [W-1:0] tail_g;
        // a read-only register takes its own departing word back
        assign tail_g = wr_v[g] ? new_word : head[g];
        seq_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .shift (shift_v[g]),
            .tail  (tail_g),
            .head  (head[g])
        );
    end

    assign busy       = flags.busy;
    assign done       = flags.done;
    assign dout_valid = flags.rd_valid;
    assign dout       = flags.rd_valid ? head_a : '0;
    assign mul_strm   = flags.strm;
    assign mul_pop    = flags.pop;
    assign mul_op     = mkind;
    assign mul_a      = flags.strm ? head_a : '0;
    assign mul_b      = (flags.strm && b_live) ? head_b : '0;

endmodule

// File: rtl/seq_cmd_unit_chk.sv
module seq_cmd_unit_chk #(
    parameter int DEPTH = 26
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic dout_valid,
    input logic mul_strm,
    input logic mul_pop,
    input logic mul_done
);

    logic [31:0] vcnt, pcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            vcnt <= '0;
            pcnt <= '0;
        end else begin
            vcnt <= done ? 32'd0 : vcnt + 32'(dout_valid);
            pcnt <= done ? 32'd0 : pcnt + 32'(mul_pop);
        end
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && !dout_valid && !mul_strm && !mul_pop));

    a_r2_accept: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r5_read_len: assert property (@(posedge clk) disable iff (rst)
        done |-> ((vcnt == 32'd0) || (vcnt == 32'(DEPTH))));

    a_r5_valid_busy: assert property (@(posedge clk) disable iff (rst)
        dout_valid |-> busy);

    a_r10_pop_after_done: assert property (@(posedge clk) disable iff (rst)
        $rose(mul_pop) |-> $past(mul_done));

    a_r10_pop_len: assert property (@(posedge clk) disable iff (rst)
        done |-> ((pcnt == 32'd0) || (pcnt == 32'(DEPTH))));

    a_r10_phase_excl: assert property (@(posedge clk) disable iff (rst)
        !(mul_strm && mul_pop));

endmodule

bind seq_cmd_unit seq_cmd_unit_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .dout_valid (dout_valid),
    .mul_strm   (mul_strm),
    .mul_pop    (mul_pop),
    .mul_done   (mul_done)
);

// File: tb/seq_cmd_unit_tb.sv
`timescale 1ns/1ps
module seq_cmd_unit_tb;

    localparam int W = 13;
    localparam int D = 26;
    localparam int N = 8;
    localparam int C_LOAD = 0, C_READ = 1, C_MUL = 2, C_ADD = 3;
    localparam int C_SUB = 4, C_MOVE = 5, C_FWD = 6, C_INV = 7;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, start, load, mul_done;
    logic [2:0] cmd_op, cmd_ra, cmd_rb, cmd_rc;
    logic [W-1:0] din, dout, mul_a, mul_b, mul_c;
    logic dout_valid, busy, done, mul_strm, mul_pop;
    logic [1:0] mul_op;

    seq_cmd_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .cmd_op(cmd_op),
        .cmd_ra(cmd_ra), .cmd_rb(cmd_rb), .cmd_rc(cmd_rc),
        .load(load), .din(din), .dout(dout), .dout_valid(dout_valid),
        .busy(busy), .done(done), .mul_op(mul_op), .mul_strm(mul_strm),
        .mul_a(mul_a), .mul_b(mul_b), .mul_done(mul_done),
        .mul_pop(mul_pop), .mul_c(mul_c)
    );

    int vectors = 0;
    int miscompares = 0;
    int mdl [N][D];
    int ldbuf [D];
    int resbuf [D];
    int tmp [D];

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int fref(input int a, input int b, input bit sub);
        int bb = sub ? (8191 - b) : b;
        int s = a + bb;
        if (s >= 8192) s = s - 8192 + 1;
        return s;
    endfunction

    task automatic issue(input int op, input int ra, input int rb, input int rc);
        start  = 1'b1;
        cmd_op = 3'(op);
        cmd_ra = 3'(ra);
        cmd_rb = 3'(rb);
        cmd_rc = 3'(rc);
        tick;
        start = 1'b0;
        chk("R2 busy after accept", int'(busy), 1);
        chk("R3 no done in decode", int'(done), 0);
        tick;
    endtask

    task automatic finish_cmd;
        chk("R3 done pulse", int'(done), 1);
        chk("R2 busy in done cycle", int'(busy), 1);
        tick;
        chk("R3 done one cycle", int'(done), 0);
        chk("R2 idle after done", int'(busy), 0);
    endtask

    task automatic run_plain(input int op, input int ra, input int rb, input int rc,
                             input int stall_at, input bit poke);
        issue(op, ra, rb, rc);
        for (int k = 0; k < D; k++) begin
            if (op == C_LOAD && k == stall_at) begin
                load = 1'b0;
                chk("R4 stall keeps busy", int'(busy), 1);
                chk("R4 no done in stall", int'(done), 0);
                tick;
            end
            chk("R3 no early done", int'(done), 0);
            if (op == C_READ) begin
                chk("R5 dout_valid", int'(dout_valid), 1);
                chk("R5 read word", int'(dout), mdl[ra][k]);
            end else begin
                chk("R5 no stray valid", int'(dout_valid), 0);
            end
            if (op == C_LOAD) begin
                din  = W'(ldbuf[k]);
                load = 1'b1;
            end
            if (poke && k == 5) begin
                start  = 1'b1;
                cmd_op = 3'(C_MOVE);
                cmd_ra = 3'd1;
                cmd_rb = 3'd4;
            end else begin
                start = 1'b0;
            end
            tick;
        end
        load  = 1'b0;
        start = 1'b0;
        chk("R5 valid drops", int'(dout_valid), 0);
        finish_cmd;
        case (op)
            C_LOAD: for (int k = 0; k < D; k++) mdl[ra][k] = ldbuf[k];
            C_ADD, C_SUB: begin
                for (int k = 0; k < D; k++) tmp[k] = fref(mdl[ra][k], mdl[rb][k], op == C_SUB);
                for (int k = 0; k < D; k++) mdl[rc][k] = tmp[k];
            end
            C_MOVE: begin
                for (int k = 0; k < D; k++) tmp[k] = mdl[ra][k];
                for (int k = 0; k < D; k++) mdl[rb][k] = tmp[k];
            end
            default: ;
        endcase
    endtask

    task automatic run_mul(input int op, input int ra, input int rb, input int rc,
                           input int waitn);
        int dst;
        int code;
        dst  = (op == C_MUL) ? rc : ra;
        code = (op == C_MUL) ? 0 : ((op == C_FWD) ? 1 : 2);
        for (int k = 0; k < D; k++)
            resbuf[k] = (mdl[ra][k] * 5 + ((op == C_MUL) ? mdl[rb][k] : 0) + k) % 8192;
        issue(op, ra, rb, rc);
        for (int k = 0; k < D; k++) begin
            chk("R10 mul_strm", int'(mul_strm), 1);
            chk("R10 mul_pop low in stream", int'(mul_pop), 0);
            chk("R10 mul_op", int'(mul_op), code);
            chk("R10 mul_a", int'(mul_a), mdl[ra][k]);
            chk("R10 mul_b", int'(mul_b), (op == C_MUL) ? mdl[rb][k] : 0);
            tick;
        end
        for (int w = 0; w < waitn; w++) begin
            chk("R10 wait strm low", int'(mul_strm), 0);
            chk("R10 wait pop low", int'(mul_pop), 0);
            chk("R10 wait no done", int'(done), 0);
            tick;
        end
        mul_done = 1'b1;
        tick;
        mul_done = 1'b0;
        for (int k = 0; k < D; k++) begin
            chk("R10 mul_pop", int'(mul_pop), 1);
            mul_c = W'(resbuf[k]);
            tick;
        end
        chk("R10 pop drops", int'(mul_pop), 0);
        finish_cmd;
        for (int k = 0; k < D; k++) mdl[dst][k] = resbuf[k];
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL R3 watchdog act=hung exp=finished");
        summary;
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; load = 1'b0; mul_done = 1'b0;
        cmd_op = '0; cmd_ra = '0; cmd_rb = '0; cmd_rc = '0;
        din = '0; mul_c = '0;
        for (int r = 0; r < N; r++) for (int k = 0; k < D; k++) mdl[r][k] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick;
        // R1: reset state at the ports
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 dout_valid", int'(dout_valid), 0);
        chk("R1 mul_strm", int'(mul_strm), 0);
        chk("R1 mul_pop", int'(mul_pop), 0);
        run_plain(C_READ, 3, 0, 0, -1, 0);      // R1 zero contents

        // R4 loads, one with a stall
        for (int k = 0; k < D; k++) ldbuf[k] = int'($urandom & 32'h1FFF);
        run_plain(C_LOAD, 0, 0, 0, -1, 0);
        for (int k = 0; k < D; k++) ldbuf[k] = int'($urandom & 32'h1FFF);
        run_plain(C_LOAD, 1, 0, 0, 0, 0);
        for (int k = 0; k < D; k++) ldbuf[k] = (k % 3 == 0) ? 8191 : int'($urandom & 32'h1FFF);
        run_plain(C_LOAD, 2, 0, 0, 25, 0);
        for (int k = 0; k < D; k++) ldbuf[k] = (k % 4 == 0) ? 0 : (k % 4 == 1) ? 8191 : (k % 4 == 2) ? 1 : 4096;
        run_plain(C_LOAD, 3, 0, 0, -1, 0);
        for (int k = 0; k < D; k++) ldbuf[k] = 8191;
        run_plain(C_LOAD, 4, 0, 0, -1, 0);
        for (int k = 0; k < D; k++) ldbuf[k] = int'($urandom & 32'h1FFF);
        run_plain(C_LOAD, 5, 0, 0, 10, 0);

        // R5 repeated reads; R2 start while busy ignored
        run_plain(C_READ, 0, 0, 0, -1, 0);
        run_plain(C_READ, 0, 0, 0, -1, 0);
        run_plain(C_READ, 1, 0, 0, -1, 1);
        run_plain(C_READ, 1, 0, 0, -1, 0);
        run_plain(C_READ, 4, 0, 0, -1, 0);      // R2 poke left r4 alone

        // R6 add, R7 subtract with carry corners
        run_plain(C_ADD, 0, 1, 6, -1, 0);
        run_plain(C_READ, 6, 0, 0, -1, 0);
        run_plain(C_READ, 0, 0, 0, -1, 0);
        run_plain(C_ADD, 4, 4, 7, -1, 0);
        run_plain(C_READ, 7, 0, 0, -1, 0);
        run_plain(C_SUB, 2, 3, 7, -1, 0);
        run_plain(C_READ, 7, 0, 0, -1, 0);
        run_plain(C_SUB, 3, 2, 6, -1, 0);
        run_plain(C_READ, 6, 0, 0, -1, 0);

        // R8 move
        run_plain(C_MOVE, 1, 5, 0, -1, 0);
        run_plain(C_READ, 5, 0, 0, -1, 0);
        run_plain(C_READ, 1, 0, 0, -1, 0);

        // R9 in place
        run_plain(C_ADD, 0, 0, 0, -1, 0);
        run_plain(C_READ, 0, 0, 0, -1, 0);
        run_plain(C_SUB, 3, 2, 3, -1, 0);
        run_plain(C_READ, 3, 0, 0, -1, 0);
        run_plain(C_MOVE, 6, 6, 0, -1, 0);
        run_plain(C_READ, 6, 0, 0, -1, 0);

        // R10 multiplier port
        run_mul(C_MUL, 0, 1, 2, 3);
        run_plain(C_READ, 2, 0, 0, -1, 0);
        run_plain(C_READ, 0, 0, 0, -1, 0);
        run_plain(C_READ, 1, 0, 0, -1, 0);
        run_mul(C_FWD, 5, 0, 0, 0);
        run_plain(C_READ, 5, 0, 0, -1, 0);
        run_mul(C_INV, 6, 0, 0, 7);
        run_plain(C_READ, 6, 0, 0, -1, 0);
        run_mul(C_MUL, 7, 7, 7, 1);
        run_plain(C_READ, 7, 0, 0, -1, 0);

        // R11 untouched registers
        run_plain(C_READ, 4, 0, 0, -1, 0);
        run_plain(C_READ, 1, 0, 0, -1, 0);
        run_plain(C_READ, 3, 0, 0, -1, 0);

        summary;
        $finish;
    end

endmodule